// File: doc/BRIEF.md
# Bus Even-Parity Generator and Checker

This block computes and checks the even parity that a 32-bit multiplexed PCI bus carries on its 4 command/byte-enable lines and 32 address/data lines. Every phase is treated alike, whether it is an address phase or a data phase and whatever the command is. This includes configuration, special-cycle and interrupt-acknowledge commands, unused byte lanes, and address bits that mean nothing for the command. The parity bit is chosen so that the total number of ones across the data lines, the command/byte-enable lines and the parity bit is even.

When the agent is driving the bus, the block registers the parity of each valid phase. It presents that parity bit, together with an output enable, on the clock that follows the phase. When the agent is receiving, the block keeps the parity it expects for the phase. On the next clock it compares that value with the parity bit sampled from the bus. A mismatch always sets a sticky detected-error status bit, which a write-one-to-clear strobe resets. A one-clock response pulse is given only when the response enable is set.

Top module: `pci_parity_unit`

## Requirements
- R1: After reset, par_out, par_oe, det_err and resp_pulse are all 0.
- R2: When phase_vld=1 and drive_sel=1 at a clock edge, par_oe is 1 after that edge. par_out is then 1 exactly when the count of ones in ad_i and cbe_i sampled at that edge is odd, so the 37 bits together hold an even count.
- R3: par_oe is 0 after any edge at which phase_vld=0, or at which drive_sel=0.
- R4: When phase_vld=1 and drive_sel=0 at edge N, par_in sampled at edge N+1 is compared with the even parity of ad_i and cbe_i taken at edge N. A mismatch makes det_err 1 after edge N+1.
- R5: A received phase whose par_in matches the expected parity leaves det_err at 0.
- R6: det_err stays 1 until a clock edge with sts_clr=1 and no new mismatch. After that edge it is 0.
- R7: If a mismatch is found at the same edge where sts_clr=1, det_err is 1 after that edge: setting wins over clearing.
- R8: resp_pulse is 1 for exactly the one cycle after a mismatch edge, and only when perr_resp_en=1 at that edge. When perr_resp_en=0, det_err is still set but resp_pulse stays 0.
- R9: A flip of any single one of the 36 covered lines, with par_in unchanged, is detected as a mismatch.
- R10: Received phases on consecutive clocks are each checked against their own par_in, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 32 | Address/data lines |
| cbe_i | input | 4 | Command/byte-enable lines |
| phase_vld | input | 1 | Current clock is a valid address phase or data transfer |
| drive_sel | input | 1 | 1: this agent drives the phase; 0: it receives it |
| par_in | input | 1 | Parity bit sampled from the bus |
| perr_resp_en | input | 1 | Parity-error response enable |
| sts_clr | input | 1 | Write-one-to-clear strobe for det_err |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | par_out is to be driven this clock |
| det_err | output | 1 | Sticky detected-parity-error status |
| resp_pulse | output | 1 | One-clock parity-error response |

## Verification
Two events can fall on the same edge: the clear strobe arriving, and a mismatch on the phase received one clock earlier. The bench provokes this by raising sts_clr on the clock that carries a wrong par_in. It then expects det_err to read 1 afterwards. With a correct par_in in the same position, it expects det_err to read 0, which shows that the clear itself acts. Back-to-back received phases also overlap a pending comparison with a fresh capture. The bench judges these by giving the first phase a correct parity and the second a wrong one, and expecting the error to appear only one clock later.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             phase_vld,
  input  logic             drive_sel,
  input  logic             par_in,
  input  logic             perr_resp_en,
  input  logic             sts_clr,
  output logic             par_out,
  output logic             par_oe,
  output logic             det_err,
  output logic             resp_pulse
);
  localparam int COVER_W = AD_W + CBE_W;

  logic [COVER_W-1:0] covered;
  logic phase_par, tx_phase, rx_phase;
  logic exp_par, chk_pend, par_bad;

  assign covered   = {cbe_i, ad_i};
  assign phase_par = ^covered;
  assign tx_phase  = phase_vld & drive_sel;
  assign rx_phase  = phase_vld & ~drive_sel;
  assign par_bad   = chk_pend & (par_in != exp_par);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_out    <= 1'b0;
      par_oe     <= 1'b0;
      exp_par    <= 1'b0;
      chk_pend   <= 1'b0;
      det_err    <= 1'b0;
      resp_pulse <= 1'b0;
    end else begin
      par_oe   <= tx_phase;
      chk_pend <= rx_phase;
      if (tx_phase) par_out <= phase_par;
      if (rx_phase) exp_par <= phase_par;
      resp_pulse <= par_bad & perr_resp_en;
      if (par_bad)      det_err <= 1'b1;
      else if (sts_clr) det_err <= 1'b0;
    end
  end

  assert_oe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && drive_sel) |=> par_oe);

  assert_even_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && drive_sel) |=> (($countones({$past(cbe_i), $past(ad_i), par_out}) % 2) == 0));

  assert_oe_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_vld && drive_sel) |=> !par_oe);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_err && !sts_clr) |=> det_err);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_pend && (par_in != exp_par) && sts_clr) |=> det_err);

  assert_resp_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_pulse |-> (det_err && $past(perr_resp_en)));

  assert_no_resp_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_resp_en |=> !resp_pulse);
endmodule

// File: tb/tb_pci_parity_unit.sv
module tb_pci_parity_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0] cbe_i = '0;
  logic phase_vld = 0, drive_sel = 0, par_in = 0, perr_resp_en = 0, sts_clr = 0;
  logic par_out, par_oe, det_err, resp_pulse;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pci_parity_unit dut (.clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
    .phase_vld(phase_vld), .drive_sel(drive_sel), .par_in(par_in),
    .perr_resp_en(perr_resp_en), .sts_clr(sts_clr), .par_out(par_out),
    .par_oe(par_oe), .det_err(det_err), .resp_pulse(resp_pulse));

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [31:0] a, input logic [3:0] c);
    return logic'(($countones(a) + $countones(c)) % 2);
  endfunction

  task automatic tx(input logic [31:0] a, input logic [3:0] c);
    logic e;
    e = even_par(a, c);
    @(negedge clk); ad_i = a; cbe_i = c; drive_sel = 1; phase_vld = 1;
    @(negedge clk); phase_vld = 0; ad_i = ~a;
    chk(par_oe == 1, "R2 oe", par_oe, 1);
    chk(par_out == e, "R2 par", par_out, e);
    @(negedge clk);
    chk(par_oe == 0, "R3 idle", par_oe, 0);
  endtask

  task automatic clr();
    @(negedge clk); sts_clr = 1;
    @(negedge clk); sts_clr = 0;
    chk(det_err == 0, "R6 clear", det_err, 0);
  endtask

  task automatic rx(input logic [31:0] a, input logic [3:0] c, input logic p,
                    input logic en, input logic clr_here, input logic exp_err,
                    input string req);
    @(negedge clk); ad_i = a; cbe_i = c; drive_sel = 0; phase_vld = 1;
    @(negedge clk); phase_vld = 0; ad_i = ~a; par_in = p; perr_resp_en = en; sts_clr = clr_here;
    chk(par_oe == 0, "R3 rx", par_oe, 0);
    @(negedge clk); sts_clr = 0; par_in = ~p;
    chk(det_err == exp_err, req, det_err, exp_err);
    chk(resp_pulse == (exp_err && en), "R8 pulse", resp_pulse, exp_err && en);
    @(negedge clk);
    chk(resp_pulse == 0, "R8 single", resp_pulse, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [35:0] v;
    logic p;
    repeat (3) @(negedge clk);
    chk(par_out == 0 && par_oe == 0 && det_err == 0 && resp_pulse == 0, "R1 reset",
        {par_out, par_oe, det_err, resp_pulse}, 0);
    rst_n = 1;
    for (int i = 0; i < 36; i++) begin
      v = 36'd1 << i;
      tx(v[31:0], v[35:32]);
    end
    v = 36'h9_1A2B_3C4D;
    for (int i = 0; i < 40; i++) begin
      v = {v[34:0], v[35] ^ v[24]} + 36'(i);
      tx(v[31:0], v[35:32]);
    end
    tx(32'hFFFF_FFFF, 4'hF);
    tx(32'h0, 4'h0);
    @(negedge clk); phase_vld = 0; drive_sel = 1;
    @(negedge clk);
    chk(par_oe == 0, "R3 no phase", par_oe, 0);
    v = 36'h5_DEAD_BEEF;
    for (int i = 0; i < 36; i++) begin
      p = even_par(v[31:0], v[35:32]);
      rx(v[31:0], v[35:32], p, 1, 0, 0, "R5 match");
      v[i] = ~v[i];
      rx(v[31:0], v[35:32], p, (i % 2) == 0, 0, 1, "R9 flip");
      v[i] = ~v[i];
      rx(v[31:0], v[35:32], p, 0, 0, 1, "R6 sticky");
      clr();
    end
    rx(32'h0000_0001, 4'h0, 1'b0, 0, 0, 1, "R4 mismatch");
    rx(32'h0000_0003, 4'h1, 1'b0, 1, 1, 1, "R7 set wins");
    clr();
    rx(32'h0000_0003, 4'h1, 1'b0, 0, 0, 1, "R8 enable off");
    rx(32'h0000_0007, 4'h0, 1'b1, 0, 1, 0, "R6 clear on match");
    // R10 back-to-back receive: first phase correct, second wrong
    @(negedge clk); ad_i = 32'h1; cbe_i = 4'h0; drive_sel = 0; phase_vld = 1;
    @(negedge clk); ad_i = 32'h3; cbe_i = 4'h0; par_in = 1; perr_resp_en = 1;
    @(negedge clk); phase_vld = 0; par_in = 1;
    chk(det_err == 0, "R10 first ok", det_err, 0);
    @(negedge clk);
    chk(det_err == 1, "R10 second bad", det_err, 1);
    chk(resp_pulse == 1, "R10 pulse", resp_pulse, 1);
    clr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule